// File: doc/BRIEF.md
# Polar Symbol Decision With Programmable Code Table

This block makes the hard decision on recovered baseband symbols. Each accepted pair of signed 16-bit in-phase and quadrature values is turned into a magnitude and an angle by an iterative vectoring CORDIC. The angle picks one of M equal sectors for the phase-shift modes. For the two amplitude-phase modes, the angle and the magnitude together pick a point on one of two rings.

The constellation index that results addresses a 16-entry table of 16-bit words. Software loads this table at run time, so any coding scheme can be used. The low byte of the selected word becomes the 8-bit output symbol. The original I and Q values of the same sample come out together with the symbol, under the same valid strobe.

The block holds one sample at a time. A new sample is taken as soon as the previous one has finished its iterations. Samples offered while one is still in flight are dropped.

Top module: `polar_symbol_decider`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` is 0 and `out_sym`, `out_i` and `out_q` are 0 until the first result appears.
- R2: A sample accepted at clock edge N produces a one-cycle `out_valid` pulse that is registered at edge N+ITER+1 (N+17 by default). No other cycle shows `out_valid`.
- R3: `out_i` and `out_q` carry, unchanged, the two's-complement I and Q values of the sample whose symbol is presented in the same cycle.
- R4: The angle runs from 0 to 1 turn, counter-clockwise from the positive I axis. For mode codes 0, 1, 2 and 3 (PSK with M = 2, 4, 8, 16), the index is floor(angle·M + 1/2) mod M. Sector 0 is centred on angle 0.
- R5: Mode code 4 (8 points on two rings). The magnitude is scaled by the CORDIC gain of about 1.6468. If this scaled magnitude is at least `ring_thr`, the index is 4 + floor(4·angle). Otherwise the index is floor(4·angle + 1/2) mod 4. The outer ring is thus rotated 45 degrees against the inner ring.
- R6: Mode code 5 (16 points on two rings). If the scaled magnitude is below `ring_thr`, the index is floor(4·angle), which places 4 points centred at 45 + k·90 degrees. Otherwise the index is 4 + (floor(12·angle + 1/2) mod 12), which places 12 points spaced 30 degrees apart with one centred on angle 0.
- R7: `out_sym` equals bits 7:0 of the table word at the constellation index. Bits 15:8 of the word never reach the output.
- R8: A table write (`tbl_we`, `tbl_addr`, `tbl_wdata`) takes effect only at an edge where no sample is in flight, or while reset is asserted. A write offered while a sample is in flight is discarded, including on the edge where a result is registered.
- R9: `in_valid` is honoured only when no sample is in iteration. The edge that registers a result can accept the next sample. A sample offered earlier is dropped and disturbs nothing.
- R10: `mode` and `ring_thr` are captured together with the sample. Changing either while the sample is in flight does not alter its result.
- R11: Mode codes 6 and 7 decode as two-point PSK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Offers a sample on `in_i`/`in_q` |
| in_i | input | 16 | In-phase sample, two's complement |
| in_q | input | 16 | Quadrature sample, two's complement |
| mode | input | 3 | Constellation selector (codes as in R4, R5, R6, R11) |
| ring_thr | input | 19 | Ring threshold on the gain-scaled magnitude, unsigned |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 4 | Table entry to write |
| tbl_wdata | input | 16 | Table word to write |
| out_valid | output | 1 | One-cycle result strobe |
| out_i | output | 16 | I value of the sample, aligned with the symbol |
| out_q | output | 16 | Q value of the sample, aligned with the symbol |
| out_sym | output | 8 | Coded symbol |

## Verification
The hardest states to reach are at the boundaries of a sample's time in flight. One is the edge where one result leaves while the next sample is taken. The other is a table write that lands while a symbol waits for its lookup. The stimulus holds `in_valid` high for many cycles with a new value every cycle, so that only the samples at the hand-over edges get in. It also issues writes to the very entry an in-flight symbol will read, and changes `mode` and `ring_thr` right after a sample is taken. Test points are built in polar form near sector centres, so the bench's floating-point reference gives the decision without any ambiguity at a boundary.

// File: rtl/psd_pkg.sv
package psd_pkg;

   localparam int PH_W   = 16;   // angle width, fraction of a full turn
   localparam int IDX_W  = 4;    // constellation index width
   localparam int DEPTH  = 1 << IDX_W;
   localparam int MAX_IT = 16;   // entries in the arctangent list

   typedef enum logic [2:0] {
      MD_PSK2  = 3'd0,
      MD_PSK4  = 3'd1,
      MD_PSK8  = 3'd2,
      MD_PSK16 = 3'd3,
      MD_RING8 = 3'd4,
      MD_RING16= 3'd5,
      MD_RSV6  = 3'd6,
      MD_RSV7  = 3'd7
   } psd_mode_e;

   // arctan(2^-i) expressed in units of 2^-16 turn
   function automatic logic [PH_W-1:0] atan_turns(input int i);
      case (i)
         0:  atan_turns = 16'd8192;
         1:  atan_turns = 16'd4836;
         2:  atan_turns = 16'd2555;
         3:  atan_turns = 16'd1297;
         4:  atan_turns = 16'd651;
         5:  atan_turns = 16'd326;
         6:  atan_turns = 16'd163;
         7:  atan_turns = 16'd81;
         8:  atan_turns = 16'd41;
         9:  atan_turns = 16'd20;
         10: atan_turns = 16'd10;
         11: atan_turns = 16'd5;
         12: atan_turns = 16'd3;
         13: atan_turns = 16'd1;
         14: atan_turns = 16'd1;
         default: atan_turns = 16'd0;
      endcase
   endfunction

endpackage

// File: rtl/psd_cordic_vec.sv
module psd_cordic_vec
   import psd_pkg::*;
#(
   parameter int W    = 16,
   parameter int ITER = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start,
   input  logic [W-1:0]         xi,
   input  logic [W-1:0]         yi,
   output logic                 busy,
   output logic                 done,
   output logic [W+2:0]         mag,
   output logic [PH_W-1:0]      phase
);
   localparam int XW = W + 3;
   localparam int CW = $clog2(ITER + 1);

   logic signed [XW-1:0] x_r, y_r, xe, ye, xs, ys;
   logic [PH_W-1:0]      z_r;
   logic [CW-1:0]        cnt, step;

   assign xe   = {{3{xi[W-1]}}, xi};
   assign ye   = {{3{yi[W-1]}}, yi};
   assign step = CW'(ITER) - cnt;
   assign xs   = x_r >>> step;
   assign ys   = y_r >>> step;
   assign busy = (cnt != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt  <= '0;
         done <= 1'b0;
         x_r  <= '0;
         y_r  <= '0;
         z_r  <= '0;
      end else begin
         done <= 1'b0;
         if (cnt == '0) begin
            if (start) begin
               // fold the left half plane onto the right one
               if (xe[XW-1]) begin
                  x_r <= -xe;
                  y_r <= -ye;
                  z_r <= PH_W'(1 << (PH_W - 1));
               end else begin
                  x_r <= xe;
                  y_r <= ye;
                  z_r <= '0;
               end
               cnt <= CW'(ITER);
            end
         end else begin
            if (!y_r[XW-1]) begin
               x_r <= x_r + ys;
               y_r <= y_r - xs;
               z_r <= z_r + atan_turns(int'(step));
            end else begin
               x_r <= x_r - ys;
               y_r <= y_r + xs;
               z_r <= z_r - atan_turns(int'(step));
            end
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) done <= 1'b1;
         end
      end
   end

   assign mag   = $unsigned(x_r);
   assign phase = z_r;

endmodule

// File: rtl/psd_sector_map.sv
module psd_sector_map
   import psd_pkg::*;
#(
   parameter int XW = 19
) (
   input  logic [2:0]        mode,
   input  logic [PH_W-1:0]   phase,
   input  logic [XW-1:0]     mag,
   input  logic [XW-1:0]     thr,
   output logic [IDX_W-1:0]  idx
);
   // PSK candidates, one per order 2^k: rounded by half a sector
   logic [IDX_W-1:0] psk_idx [1:4];

   for (genvar k = 1; k <= 4; k++) begin : g_psk
      logic [PH_W-1:0] shifted;
      assign shifted    = phase + PH_W'(1 << (PH_W - 1 - k));
      assign psk_idx[k] = IDX_W'(shifted >> (PH_W - k));
   end

   logic outer;
   assign outer = (mag >= thr);

   // eight points: inner ring on the axes, outer ring on the diagonals
   logic [IDX_W-1:0] ring8_idx;
   assign ring8_idx = outer ? {2'b01, phase[PH_W-1 -: 2]}
                            : {2'b00, psk_idx[2][1:0]};

   // sixteen points: inner ring of four on the diagonals, outer ring of twelve
   localparam logic [PH_W-1:0] HALF12 = PH_W'(((1 << PH_W) + 12) / 24);
   logic [PH_W-1:0]   ph12;
   logic [PH_W+3:0]   prod12;
   logic [IDX_W-1:0]  ring16_idx;
   logic              unused_prod;

   assign ph12        = phase + HALF12;
   assign prod12      = {4'b0, ph12} * (PH_W+4)'(12);
   assign unused_prod = ^prod12[PH_W-1:0];
   assign ring16_idx  = outer ? (IDX_W'(4) + prod12[PH_W+3:PH_W])
                              : {2'b00, phase[PH_W-1 -: 2]};

   always_comb begin
      case (psd_mode_e'(mode))
         MD_PSK4:   idx = psk_idx[2];
         MD_PSK8:   idx = psk_idx[3];
         MD_PSK16:  idx = psk_idx[4];
         MD_RING8:  idx = ring8_idx;
         MD_RING16: idx = ring16_idx;
         default:   idx = psk_idx[1];
      endcase
   end

endmodule

// File: rtl/psd_code_table.sv
module psd_code_table #(
   parameter int AW = 4,
   parameter int TW = 16,
   parameter int SW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [TW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [SW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [TW-1:0] ent [DEPTH];

   // no reset: the table is loaded by its owner, also during reset
   always_ff @(posedge clk) begin
      if (we) ent[waddr] <= wdata;
   end

   assign rdata = ent[raddr][SW-1:0];

   if (TW > SW) begin : g_wide
      logic unused_hi;
      assign unused_hi = ^ent[raddr][TW-1:SW];
   end

endmodule

// File: rtl/polar_symbol_decider.sv
module polar_symbol_decider
   import psd_pkg::*;
#(
   parameter int W    = 16,
   parameter int ITER = 16,
   parameter int TW   = 16,
   parameter int SW   = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [W-1:0]     in_i,
   input  logic [W-1:0]     in_q,
   input  logic [2:0]       mode,
   input  logic [W+2:0]     ring_thr,
   input  logic             tbl_we,
   input  logic [IDX_W-1:0] tbl_addr,
   input  logic [TW-1:0]    tbl_wdata,
   output logic             out_valid,
   output logic [W-1:0]     out_i,
   output logic [W-1:0]     out_q,
   output logic [SW-1:0]    out_sym
);
   localparam int XW  = W + 3;
   localparam int LAT = ITER + 1;

   initial begin
      assert (W >= 8) else $fatal(1, "W must be at least 8");
      assert (ITER >= 8 && ITER <= MAX_IT) else $fatal(1, "ITER out of range");
      assert (SW <= TW) else $fatal(1, "symbol wider than table word");
   end

   logic             c_busy, c_done, accept, idle;
   logic [XW-1:0]    c_mag;
   logic [PH_W-1:0]  c_phase;
   logic [W-1:0]     hold_i, hold_q;
   logic [2:0]       hold_mode;
   logic [XW-1:0]    hold_thr;
   logic [IDX_W-1:0] sel_idx;
   logic [SW-1:0]    tbl_rdata;

   assign accept = in_valid & ~c_busy;
   assign idle   = ~c_busy & ~c_done;

   psd_cordic_vec #(.W(W), .ITER(ITER)) u_cordic (
      .clk   (clk),
      .rst   (rst),
      .start (in_valid),
      .xi    (in_i),
      .yi    (in_q),
      .busy  (c_busy),
      .done  (c_done),
      .mag   (c_mag),
      .phase (c_phase)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_i    <= '0;
         hold_q    <= '0;
         hold_mode <= '0;
         hold_thr  <= '0;
      end else if (accept) begin
         hold_i    <= in_i;
         hold_q    <= in_q;
         hold_mode <= mode;
         hold_thr  <= ring_thr;
      end
   end

   psd_sector_map #(.XW(XW)) u_map (
      .mode  (hold_mode),
      .phase (c_phase),
      .mag   (c_mag),
      .thr   (hold_thr),
      .idx   (sel_idx)
   );

   psd_code_table #(.AW(IDX_W), .TW(TW), .SW(SW)) u_tbl (
      .clk   (clk),
      .we    (tbl_we & idle),
      .waddr (tbl_addr),
      .wdata (tbl_wdata),
      .raddr (sel_idx),
      .rdata (tbl_rdata)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_i     <= '0;
         out_q     <= '0;
         out_sym   <= '0;
      end else begin
         out_valid <= c_done;
         if (c_done) begin
            out_i   <= hold_i;
            out_q   <= hold_q;
            out_sym <= tbl_rdata;
         end
      end
   end

endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
   parameter int W   = 16,
   parameter int SW  = 8,
   parameter int LAT = 17
) (
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic          busy,
   input logic [W-1:0]  in_i,
   input logic [W-1:0]  in_q,
   input logic          out_valid,
   input logic [W-1:0]  out_i,
   input logic [W-1:0]  out_q,
   input logic [SW-1:0] out_sym
);
   localparam int CW = $clog2(LAT + 1);

   logic [CW-1:0] cnt;
   logic [W-1:0]  ri, rq, oi, oq;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
         ri  <= '0;
         rq  <= '0;
         oi  <= '0;
         oq  <= '0;
      end else begin
         if (in_valid && !busy) begin
            cnt <= CW'(LAT);
            ri  <= in_i;
            rq  <= in_q;
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end
         if (cnt == CW'(1)) begin
            oi <= ri;
            oq <= rq;
         end
      end
   end

   // R2
   a_r2_latency: assert property (@(posedge clk) disable iff (rst)
      (cnt == CW'(1)) |=> out_valid);
   // R2
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
      (cnt != CW'(1)) |=> !out_valid);
   // R3
   a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_i == oi && out_q == oq));
   // R7
   a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> ($stable(out_sym) && $stable(out_i) && $stable(out_q)));
   // R9
   a_r9_busy_window: assert property (@(posedge clk) disable iff (rst)
      busy |-> (cnt > CW'(1)));

endmodule

bind polar_symbol_decider psd_checker #(.W(W), .SW(SW), .LAT(LAT)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .busy      (c_busy),
   .in_i      (in_i),
   .in_q      (in_q),
   .out_valid (out_valid),
   .out_i     (out_i),
   .out_q     (out_q),
   .out_sym   (out_sym)
);

// File: tb/tb_polar_symbol_decider.sv
module tb_polar_symbol_decider;
   localparam int  CLK_PERIOD = 10;
   localparam int  LAT        = 17;
   localparam real PI         = 3.14159265358979;
   localparam real GAIN       = 1.6467602;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [15:0] in_i = '0, in_q = '0;
   logic [2:0]  mode = '0;
   logic [18:0] ring_thr = '0;
   logic        tbl_we = 1'b0;
   logic [3:0]  tbl_addr = '0;
   logic [15:0] tbl_wdata = '0;
   logic        out_valid;
   logic [15:0] out_i, out_q;
   logic [7:0]  out_sym;

   polar_symbol_decider dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
      .mode(mode), .ring_thr(ring_thr), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
      .tbl_wdata(tbl_wdata), .out_valid(out_valid), .out_i(out_i),
      .out_q(out_q), .out_sym(out_sym)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   int cur_req  = 4;
   int unsigned seed = 32'h1234_5678;

   typedef struct {
      int i;
      int q;
      int idx;
      int req;
   } rec_t;

   rec_t        pend[$];
   rec_t        rec;
   logic [15:0] mtbl [16];
   int          mcnt = 0;
   bit          exp_valid = 0;
   int          exp_i = 0, exp_q = 0, exp_sym = 0, exp_req = 2;
   bit          m_idle, m_acc;

   function automatic int rnd(real x);
      return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
   endfunction

   function automatic real urand();
      seed = seed * 32'd1103515245 + 32'd12345;
      return real'((seed >> 8) & 32'hFFFF) / 65536.0;
   endfunction

   // decision reference from the requirements, in floating point
   function automatic int ref_idx(int md, int i, int q, int thr);
      real ph, mg;
      bit  outer;
      ph = $atan2(real'(q), real'(i)) / (2.0 * PI);
      if (ph < 0.0) ph = ph + 1.0;
      if (ph >= 1.0) ph = ph - 1.0;
      mg = GAIN * $sqrt(real'(i) * real'(i) + real'(q) * real'(q));
      outer = (mg >= real'(thr));
      case (md)
         1: return $rtoi($floor(ph * 4.0 + 0.5)) % 4;
         2: return $rtoi($floor(ph * 8.0 + 0.5)) % 8;
         3: return $rtoi($floor(ph * 16.0 + 0.5)) % 16;
         4: return outer ? 4 + ($rtoi($floor(ph * 4.0)) % 4)
                         : $rtoi($floor(ph * 4.0 + 0.5)) % 4;
         5: return outer ? 4 + ($rtoi($floor(ph * 12.0 + 0.5)) % 12)
                         : $rtoi($floor(ph * 4.0)) % 4;
         default: return $rtoi($floor(ph * 2.0 + 0.5)) % 2;
      endcase
   endfunction

   // cycle-by-cycle reference model
   always @(posedge clk) begin
      if (rst) begin
         mcnt = 0;
         exp_valid = 0;
         exp_i = 0; exp_q = 0; exp_sym = 0;
         pend.delete();
         if (tbl_we) mtbl[tbl_addr] = tbl_wdata;
      end else begin
         m_idle = (mcnt == 0);
         m_acc  = in_valid && (mcnt <= 1);
         exp_valid = 0;
         if (mcnt == 1) begin
            rec = pend.pop_front();
            exp_valid = 1;
            exp_i = rec.i;
            exp_q = rec.q;
            exp_sym = int'(mtbl[rec.idx][7:0]);
            exp_req = rec.req;
         end
         if (mcnt != 0) mcnt = mcnt - 1;
         if (tbl_we && m_idle) mtbl[tbl_addr] = tbl_wdata;
         if (m_acc) begin
            rec.i   = int'($signed(in_i));
            rec.q   = int'($signed(in_q));
            rec.idx = ref_idx(int'(mode), rec.i, rec.q, int'(ring_thr));
            rec.req = cur_req;
            pend.push_back(rec);
            mcnt = LAT;
         end
      end
   end

   // comparison on every clock, away from the active edge
   always @(negedge clk) begin
      if (!rst) begin
         n_checks++;
         if (out_valid !== exp_valid) begin
            n_fail++;
            $display("FAIL R2: out_valid actual=%0d expected=%0d", out_valid, exp_valid);
         end
         if (exp_valid) begin
            n_checks++;
            if (int'($signed(out_i)) != exp_i || int'($signed(out_q)) != exp_q) begin
               n_fail++;
               $display("FAIL R3: I/Q actual=%0d,%0d expected=%0d,%0d",
                        $signed(out_i), $signed(out_q), exp_i, exp_q);
            end
            n_checks++;
            if (int'(out_sym) != exp_sym) begin
               n_fail++;
               $display("FAIL R%0d: symbol actual=%0d expected=%0d", exp_req, out_sym, exp_sym);
            end
         end
      end
   end

   task automatic put(int md, int thr, real turns, real r);
      mode     = 3'(md);
      ring_thr = 19'(thr);
      in_i     = 16'(rnd(r * $cos(2.0 * PI * turns)));
      in_q     = 16'(rnd(r * $sin(2.0 * PI * turns)));
   endtask

   task automatic launch(int md, int thr, real turns, real r);
      @(negedge clk);
      put(md, thr, turns, r);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send(int md, int thr, real turns, real r);
      launch(md, thr, turns, r);
      repeat (LAT + 2) @(negedge clk);
   endtask

   task automatic send_raw(int md, int i, int q);
      @(negedge clk);
      mode = 3'(md);
      in_i = 16'(i);
      in_q = 16'(q);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (LAT + 2) @(negedge clk);
   endtask

   task automatic write_tbl(int a, int d);
      @(negedge clk);
      tbl_we = 1'b1;
      tbl_addr = 4'(a);
      tbl_wdata = 16'(d);
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL R2: watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      int m, s;
      real off;
      // R1: reset state, R8: table loaded while reset is held
      repeat (3) @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0 || out_sym !== 8'd0 || out_i !== 16'd0 || out_q !== 16'd0) begin
         n_fail++;
         $display("FAIL R1: reset outputs actual=%0d/%0d/%0d expected=0/0/0",
                  out_valid, out_sym, out_i);
      end
      for (int k = 0; k < 16; k++) begin
         tbl_we = 1'b1;
         tbl_addr = 4'(k);
         tbl_wdata = {8'(8'hC0 + k), 8'(k * 7 + 8'h31)};
         @(negedge clk);
      end
      tbl_we = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0 || out_sym !== 8'd0) begin
         n_fail++;
         $display("FAIL R1: after release actual=%0d/%0d expected=0/0", out_valid, out_sym);
      end

      // R4: PSK sectors, four orders
      cur_req = 4;
      for (int md = 0; md < 4; md++) begin
         m = 2 << md;
         for (int n = 0; n < 6; n++) begin
            s = $rtoi(urand() * real'(m)) % m;
            off = (urand() - 0.5) * 0.6 / real'(m);
            send(md, 0, real'(s) / real'(m) + off, 20000.0 + 10000.0 * urand());
         end
      end
      send_raw(1, -32768, 0);
      send_raw(1, 0, -32768);
      send_raw(2, 32767, 32767);
      send_raw(3, -32768, -32768);

      // R5: eight points on two rings
      cur_req = 5;
      for (int n = 0; n < 10; n++) begin
         s = $rtoi(urand() * 4.0) % 4;
         off = (urand() - 0.5) * 0.1;
         if (n % 2 == 0) send(4, 30000, real'(s) / 4.0 + off, 9000.0);
         else            send(4, 30000, real'(s) / 4.0 + 0.125 + off, 28000.0);
      end

      // R6: sixteen points on two rings
      cur_req = 6;
      for (int n = 0; n < 14; n++) begin
         if (n % 3 == 0) begin
            s = $rtoi(urand() * 4.0) % 4;
            send(5, 30000, real'(s) / 4.0 + 0.125 + (urand() - 0.5) * 0.1, 9000.0);
         end else begin
            s = $rtoi(urand() * 12.0) % 12;
            send(5, 30000, real'(s) / 12.0 + (urand() - 0.5) * 0.04, 28000.0);
         end
      end

      // R11: reserved mode codes behave as two-point PSK
      cur_req = 11;
      send(6, 0, 0.5 + 0.05, 25000.0);
      send(7, 0, 0.02, 25000.0);
      send(6, 0, 0.97, 25000.0);

      // R7: only the low byte of a reprogrammed word reaches the output
      cur_req = 7;
      write_tbl(2, 16'hFF5A);
      write_tbl(9, 16'h00E7);
      send(1, 0, 0.5, 25000.0);
      send(3, 0, 9.0 / 16.0, 25000.0);

      // R8: write offered during flight is discarded
      cur_req = 8;
      launch(1, 0, 0.25, 25000.0);
      repeat (4) @(negedge clk);
      write_tbl(1, 16'h1199);
      repeat (LAT) @(negedge clk);
      send(1, 0, 0.25, 25000.0);

      // R9: in_valid held high, only hand-over edges accept
      cur_req = 9;
      @(negedge clk);
      in_valid = 1'b1;
      for (int n = 0; n < 45; n++) begin
         put(1, 0, real'(n % 4) / 4.0, 15000.0 + 300.0 * real'(n));
         @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (LAT + 2) @(negedge clk);

      // R10: mode and threshold changed after acceptance
      cur_req = 10;
      launch(5, 60000, 1.0 / 12.0, 28000.0);
      mode = 3'd0;
      ring_thr = 19'd1000;
      repeat (LAT + 2) @(negedge clk);
      launch(4, 1000, 0.125, 9000.0);
      mode = 3'd3;
      ring_thr = 19'd70000;
      repeat (LAT + 2) @(negedge clk);

      summary();
      $finish;
   end

endmodule